// File: doc/BRIEF.md
# Serial Port with Shared Flow-Control Pin

This block is an asynchronous serial transmitter and receiver whose hardware flow control runs over a single input, `fc_pin`. A small configuration register sets two bits: whether flow control is enabled, and which job the pin does. In clear-to-send mode the pin gates the transmitter one frame at a time. In receive-enable mode it allows or blocks the receiver. With flow control off, the pin level has no effect.

Software writes a byte with a one-cycle `tx_wr` strobe into a holding register. The holding register moves into the shift register when the transmitter is idle and the gate allows it. Each received frame produces a one-cycle `rx_valid` pulse with the byte and a framing-error flag. Bit timing comes from a clock divider. The divider makes a tick every `CLKS_PER_TICK` clocks, and `OVS` ticks make one bit. The flow-control pin and the serial input are both asynchronous and each passes through a two-flop synchronizer.

Top module: `uart_fc_top`

## Requirements
- R1: After reset, `txd` is 1, `tx_empty` is 1 and `rx_valid` is 0. The configuration comes up with flow control disabled and the pin function set to clear-to-send.
- R2: A frame has 10 bits: one start bit at 0, eight data bits sent least significant bit first, and one stop bit at 1. Each bit lasts `OVS` ticks and each tick lasts `CLKS_PER_TICK` clocks. The line idles at 1.
- R3: Clear-to-send mode is flow control 1 with pin select 0. In this mode, while the synchronized `fc_pin` is 0, a written byte stays in the holding register: `tx_empty` stays 0, `txd` stays 1, and no frame starts.
- R4: In clear-to-send mode the pin is checked only when a frame is about to start. Dropping `fc_pin` during a frame does not cut that frame short. A byte written during that frame then waits until the pin returns to 1.
- R5: Receive-enable mode is flow control 1 with pin select 1. In this mode the receiver accepts a start bit only while the synchronized `fc_pin` is 1. A frame that arrives while the pin is 0 gives no `rx_valid`. The transmitter is not gated in this mode.
- R6: With flow control 0, the transmitter sends whenever a byte is waiting and the receiver is always enabled, whatever the level of `fc_pin` or the pin select.
- R7: When the transmitter is idle and not gated, a `tx_wr` pulse makes `tx_empty` go to 0 for exactly one cycle. `tx_empty` returns to 1 on the edge that moves the byte into the shift register, and `txd` goes to 0 (the start bit) on that same edge.
- R8: The receiver checks each bit near its middle, counting `OVS` ticks per bit from the detected start edge. It confirms the start bit at mid-bit. For each complete frame it gives a one-cycle `rx_valid` pulse, with the byte on `rx_data`, least significant bit first on the wire.
- R9: If the stop bit is sampled at 0, `rx_valid` pulses with `rx_frame_err` set to 1. The receiver then waits for the line to return to 1 before it looks for a new start bit. A correct frame after that is received with `rx_frame_err` set to 0.
- R10: The two configuration bits load only on a `cfg_wr` pulse. Changing `cfg_fc_en` or `cfg_pin_sel` without a strobe has no effect on gating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Strobe that loads the two configuration bits |
| cfg_fc_en | input | 1 | Flow-control enable value to load |
| cfg_pin_sel | input | 1 | Pin function to load: 0 clear-to-send, 1 receive-enable |
| fc_pin | input | 1 | Asynchronous flow-control input, active high |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | DATA_W | Byte to transmit |
| tx_empty | output | 1 | 1 when the holding register is free |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Asynchronous serial input |
| rx_valid | output | 1 | One-cycle pulse for each received frame |
| rx_data | output | DATA_W | Received byte |
| rx_frame_err | output | 1 | Stop bit was 0 for the frame shown with `rx_valid` |

## Verification
The assertions assume that `fc_pin` and `rxd` may change at any time, because both are synchronized before any decision uses them. They also assume that `tx_wr` is not pulsed while a byte is already waiting, since a write over a waiting byte would replace it. The stimulus writes a byte only after the previous one has left the holding register, or once on purpose while the gate is closed. It changes the configuration only between frames. Serial frames driven from outside keep exact bit periods, and after the deliberately bad stop bit the line is held low longer before it goes high again.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

  typedef enum logic {
    PIN_CTS  = 1'b0,
    PIN_RXEN = 1'b1
  } pin_fn_e;

  typedef enum logic {
    TX_IDLE  = 1'b0,
    TX_SHIFT = 1'b1
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_STOP  = 3'd3,
    RX_WAITH = 3'd4
  } rx_state_e;

  // transmitter may start a frame
  function automatic logic tx_gate(input logic fc_en, input pin_fn_e fn, input logic pin);
    return !fc_en || (fn == PIN_RXEN) || pin;
  endfunction

  // receiver may accept a start bit
  function automatic logic rx_gate(input logic fc_en, input pin_fn_e fn, input logic pin);
    return !fc_en || (fn == PIN_CTS) || pin;
  endfunction

endpackage

// File: rtl/fc_sync.sv
module fc_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= {STAGES{RESET_VAL}};
    else        ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/fc_tx.sv
module fc_tx
  import uart_fc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              gate_ok,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx_empty,
  output logic              txd
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int SUB_W   = $clog2(OVS);
  localparam int CNT_W   = $clog2(FRAME_W);

  function automatic logic [FRAME_W-1:0] frame_bits(input logic [DATA_W-1:0] b);
    return {1'b1, b, 1'b0};
  endfunction

  tx_state_e          state;
  logic [DATA_W-1:0]  hold_q;
  logic               hold_full;
  logic [FRAME_W-1:0] shreg;
  logic [SUB_W-1:0]   sub;
  logic [CNT_W-1:0]   bitn;

  logic tx_start, bit_end, frame_end;
  assign tx_start  = (state == TX_IDLE) && hold_full && gate_ok;
  assign bit_end   = (state == TX_SHIFT) && tick && (sub == SUB_W'(OVS-1));
  assign frame_end = bit_end && (bitn == CNT_W'(FRAME_W-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= TX_IDLE;
      hold_q    <= '0;
      hold_full <= 1'b0;
      shreg     <= '1;
      sub       <= '0;
      bitn      <= '0;
    end else begin
      if (tx_start) hold_full <= 1'b0;
      if (wr) begin
        hold_q    <= wr_data;
        hold_full <= 1'b1;
      end
      case (state)
        TX_IDLE: if (tx_start) begin
          state <= TX_SHIFT;
          shreg <= frame_bits(hold_q);
          sub   <= '0;
          bitn  <= '0;
        end
        TX_SHIFT: if (tick) begin
          if (bit_end) begin
            sub   <= '0;
            shreg <= {1'b1, shreg[FRAME_W-1:1]};
            if (frame_end) state <= TX_IDLE;
            else           bitn  <= bitn + 1'b1;
          end else begin
            sub <= sub + 1'b1;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  assign tx_empty = !hold_full;
  assign txd      = (state == TX_SHIFT) ? shreg[0] : 1'b1;

  assert_tx_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_IDLE && hold_full && !gate_ok) |=> hold_full);
  assert_tx_frame_runs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_SHIFT && !frame_end) |=> (state == TX_SHIFT));
  assert_tx_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == TX_SHIFT) |-> !txd);
  assert_tx_empty_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && !wr) |=> tx_empty);
endmodule

// File: rtl/fc_rx.sv
module fc_rx
  import uart_fc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd_s,
  input  logic              rx_en,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_frame_err
);
  localparam int SUB_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_W);
  localparam int MID   = OVS/2 - 1;

  rx_state_e         state;
  logic [SUB_W-1:0]  sub;
  logic [BIT_W-1:0]  bitn;
  logic [DATA_W-1:0] shreg;

  logic mid_hit, full_hit;
  assign mid_hit  = tick && (sub == SUB_W'(MID));
  assign full_hit = tick && (sub == SUB_W'(OVS-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= RX_IDLE;
      sub          <= '0;
      bitn         <= '0;
      shreg        <= '0;
      rx_valid     <= 1'b0;
      rx_data      <= '0;
      rx_frame_err <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (state)
        RX_IDLE: if (tick && !rxd_s && rx_en) begin
          state <= RX_START;
          sub   <= '0;
        end
        RX_START: if (tick) begin
          if (mid_hit) begin
            sub   <= '0;
            bitn  <= '0;
            state <= rxd_s ? RX_IDLE : RX_DATA;
          end else sub <= sub + 1'b1;
        end
        RX_DATA: if (tick) begin
          if (full_hit) begin
            sub   <= '0;
            shreg <= {rxd_s, shreg[DATA_W-1:1]};
            if (bitn == BIT_W'(DATA_W-1)) state <= RX_STOP;
            else                          bitn  <= bitn + 1'b1;
          end else sub <= sub + 1'b1;
        end
        RX_STOP: if (tick) begin
          if (full_hit) begin
            rx_valid     <= 1'b1;
            rx_data      <= shreg;
            rx_frame_err <= !rxd_s;
            state        <= rxd_s ? RX_IDLE : RX_WAITH;
          end else sub <= sub + 1'b1;
        end
        RX_WAITH: if (rxd_s) state <= RX_IDLE;
        default: state <= RX_IDLE;
      endcase
    end
  end

  assert_rx_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_IDLE && !rx_en) |=> (state == RX_IDLE));
  assert_rx_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_rx_wait_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_WAITH && !rxd_s) |=> (state == RX_WAITH));
endmodule

// File: rtl/uart_fc_top.sv
module uart_fc_top
  import uart_fc_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int OVS           = 16,
  parameter int CLKS_PER_TICK = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_fc_en,
  input  logic              cfg_pin_sel,
  input  logic              fc_pin,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_empty,
  output logic              txd,
  input  logic              rxd,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_frame_err
);
  localparam int DIV_W = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;

  logic    en_q;
  pin_fn_e fn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      fn_q <= PIN_CTS;
    end else if (cfg_wr) begin
      en_q <= cfg_fc_en;
      fn_q <= pin_fn_e'(cfg_pin_sel);
    end
  end

  logic [DIV_W-1:0] div_q;
  logic             tick;
  assign tick = (div_q == DIV_W'(CLKS_PER_TICK-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end

  logic pin_s, rxd_s, tx_ok, rx_ok;

  fc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(fc_pin), .q(pin_s));
  fc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_rxd_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s));

  assign tx_ok = tx_gate(en_q, fn_q, pin_s);
  assign rx_ok = rx_gate(en_q, fn_q, pin_s);

  fc_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate_ok(tx_ok),
    .wr(tx_wr), .wr_data(tx_data), .tx_empty(tx_empty), .txd(txd));

  fc_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd_s(rxd_s), .rx_en(rx_ok),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_frame_err(rx_frame_err));

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ($stable(en_q) && $stable(fn_q)));
  assert_tx_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (txd && tx_empty));
endmodule

// File: tb/sim_uart_fc_top.sv
module sim_uart_fc_top;
  localparam int CLK_PERIOD = 10;
  localparam int CPT        = 2;
  localparam int BIT_CLKS   = 16 * CPT;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0, cfg_fc_en = 1'b0, cfg_pin_sel = 1'b0;
  logic       fc_pin = 1'b0;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_empty, txd, rx_valid, rx_frame_err;
  logic [7:0] rx_data;
  logic       loop_sel = 1'b1, bench_rxd = 1'b1;
  logic       rxd;

  assign rxd = loop_sel ? txd : bench_rxd;

  uart_fc_top #(.DATA_W(8), .OVS(16), .CLKS_PER_TICK(CPT), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_fc_en(cfg_fc_en),
    .cfg_pin_sel(cfg_pin_sel), .fc_pin(fc_pin), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_empty(tx_empty), .txd(txd), .rxd(rxd), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_frame_err(rx_frame_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_errors = 0, unexpected = 0, cycles = 0;
  logic [8:0] sb_q[$];

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every received frame
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (sb_q.size() == 0) begin
        unexpected++;
        check(1'b0, "R5 unexpected rx_valid", {rx_frame_err, rx_data}, 0);
      end else begin
        logic [8:0] e;
        e = sb_q.pop_front();
        check({rx_frame_err, rx_data} == e, "R8/R9 received frame",
              {rx_frame_err, rx_data}, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk); tx_data = b; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic set_cfg(input logic en, input logic sel);
    @(negedge clk); cfg_fc_en = en; cfg_pin_sel = sel; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 3000 && sb_q.size() != 0; i++) @(negedge clk);
    check(sb_q.size() == 0, tag, sb_q.size(), 0);
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic drive_frame(input logic [7:0] b, input logic stop);
    logic [9:0] f;
    f = {stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      bench_rxd = f[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
  endtask

  initial begin
    int low_len;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(txd == 1'b1, "R1 txd idle", txd, 1);
    check(tx_empty == 1'b1, "R1 tx_empty", tx_empty, 1);
    check(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);

    // reset config: flow control off, so a low pin does not block (R1, R6)
    fc_pin = 1'b0;
    sb_q.push_back({1'b0, 8'hA5}); send(8'hA5);
    drain("R1 default config sends");

    // exact tx_empty timing and start bit (R7, R2)
    @(negedge clk); tx_data = 8'h3C; tx_wr = 1'b1;
    sb_q.push_back({1'b0, 8'h3C});
    @(negedge clk); tx_wr = 1'b0;
    check(tx_empty == 1'b0, "R7 empty low one cycle", tx_empty, 0);
    @(negedge clk);
    check(tx_empty == 1'b1, "R7 empty back high", tx_empty, 1);
    check(txd == 1'b0, "R2 start bit", txd, 0);
    drain("R7 frame received");

    // start bit plus bit0=0 gives two bit times low (R2)
    sb_q.push_back({1'b0, 8'hFE}); send(8'hFE);
    while (txd) @(negedge clk);
    low_len = 0;
    while (!txd) begin low_len++; @(negedge clk); end
    check(low_len >= 2*BIT_CLKS-2 && low_len <= 2*BIT_CLKS+1, "R2 bit period", low_len, 2*BIT_CLKS);
    drain("R2 frame received");
    sb_q.push_back({1'b0, 8'h00}); send(8'h00); drain("R2 all zero");
    sb_q.push_back({1'b0, 8'hFF}); send(8'hFF); drain("R2 all one");

    // flow control off with pin low, both selects (R6)
    set_cfg(1'b0, 1'b1);
    sb_q.push_back({1'b0, 8'h5A}); send(8'h5A); drain("R6 off sel1");
    set_cfg(1'b0, 1'b0);
    sb_q.push_back({1'b0, 8'hC3}); send(8'hC3); drain("R6 off sel0");

    // clear-to-send blocked (R3), unstrobed config change ignored (R10)
    set_cfg(1'b1, 1'b0);
    @(negedge clk); cfg_fc_en = 1'b0; cfg_pin_sel = 1'b1;
    send(8'h81);
    repeat (500) @(negedge clk);
    check(tx_empty == 1'b0, "R3 byte held", tx_empty, 0);
    check(txd == 1'b1, "R3 line idle", txd, 1);
    check(tx_empty == 1'b0, "R10 config unchanged without strobe", tx_empty, 0);

    // open the gate, drop it mid-frame (R4)
    sb_q.push_back({1'b0, 8'h81});
    fc_pin = 1'b1;
    while (txd) @(negedge clk);
    repeat (100) @(negedge clk);
    fc_pin = 1'b0;
    send(8'h42);
    drain("R4 frame completes after pin drop");
    repeat (400) @(negedge clk);
    check(tx_empty == 1'b0, "R4 next byte waits", tx_empty, 0);
    check(txd == 1'b1, "R4 no new frame", txd, 1);
    sb_q.push_back({1'b0, 8'h42});
    fc_pin = 1'b1;
    drain("R4 held byte sent");

    // receive-enable mode (R5)
    set_cfg(1'b1, 1'b1);
    fc_pin = 1'b0;
    send(8'h55);
    repeat (400) @(negedge clk);
    check(tx_empty == 1'b1, "R5 tx not gated", tx_empty, 1);
    check(unexpected == 0, "R5 no frame while disabled", unexpected, 0);
    fc_pin = 1'b1;
    repeat (4) @(negedge clk);
    sb_q.push_back({1'b0, 8'h66}); send(8'h66);
    drain("R5 frame while enabled");

    // framing error and recovery (R9)
    set_cfg(1'b0, 1'b0);
    loop_sel = 1'b0; bench_rxd = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);
    sb_q.push_back({1'b1, 8'h5A});
    drive_frame(8'h5A, 1'b0);
    bench_rxd = 1'b0;
    repeat (2*BIT_CLKS) @(negedge clk);
    bench_rxd = 1'b1;
    repeat (2*BIT_CLKS) @(negedge clk);
    check(sb_q.size() == 0, "R9 error frame reported", sb_q.size(), 0);
    sb_q.push_back({1'b0, 8'h99});
    drive_frame(8'h99, 1'b1);
    drain("R9 recovery frame");
    check(unexpected == 0, "R9 no spurious frame", unexpected, 0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule